// File: doc/BRIEF.md
# Two-Channel ADC Poll Sequencer

This block drives an existing SPI master so that it reads both channels of a two-channel serial ADC. The block writes a 17-bit command word into the master's transmit register and raises a send request for one cycle. It then treats the master's busy flag as a handshake: it first waits for busy to go high, then waits for busy to go low. It also sets the master's clock polarity and phase once, during a setup state that follows reset.

The ADC returns each conversion during the frame after the one that carried its command. A single start request therefore runs three frames: an X-channel command, a Y-channel command, and a dummy X-channel command. The last frame only pushes the Y result out. The word received at the end of the second frame becomes the X result, and the word received at the end of the third frame becomes the Y result. Each result register has a one-cycle valid strobe. A done pulse marks the return to idle.

The result outputs are plain register-plus-strobe outputs with no ready input, so there is no back-pressure. A result stays stable until the next update of the same channel. A consumer that needs to keep it must capture it in the cycle its valid strobe is high, or before the next start.

Top module: `adc_pair_poller`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `spi_send`, `x_valid`, `y_valid` and `done` are low and both results are zero.
- R2: From the second cycle after reset is released, `spi_cpol` is 0 (clock idles low) and `spi_cpha` is 1 (first edge half an SCLK period after chip-select).
- R3: In idle, and with `start` low, no send request is issued.
- R4: One start issues exactly three transfers with command words 0x1A000 (X channel), 0x1E000 (Y channel) and 0x1A000 again, in that order. The two words differ only in bit 14, the channel select.
- R5: `spi_send` is high for exactly one cycle per transfer, and `spi_tx` holds the command word in that cycle.
- R6: A new send request is issued only after busy has risen and then fallen following the previous request. This holds however long busy takes to rise or stays high.
- R7: A stored sample is `spi_rx` bits 11 down to 1, zero-extended to 16 bits. All other receive bits are ignored. The X result comes from the word received at the end of the second frame, and the Y result from the word received at the end of the third frame.
- R8: `x_valid` and `y_valid` each pulse for one cycle, once per start, in the cycle their result changes. The X result is posted before the Y result, and each result holds its value afterwards.
- R9: `done` pulses for one cycle, in the same cycle as `y_valid`, after busy falls at the end of the third frame. The block then returns to idle.
- R10: A `start` raised while a read pair is in progress has no effect: that pair still issues exactly three transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one X/Y read pair (taken in idle only) |
| spi_busy | input | 1 | SPI master busy flag |
| spi_rx | input | 17 | Word received by the SPI master in its last frame |
| spi_tx | output | 17 | Command word for the SPI master |
| spi_send | output | 1 | One-cycle transfer request |
| spi_cpol | output | 1 | Clock polarity setting for the master |
| spi_cpha | output | 1 | Clock phase setting for the master |
| x_result | output | 16 | X-channel sample, zero-extended |
| x_valid | output | 1 | One-cycle strobe on X result update |
| y_result | output | 16 | Y-channel sample, zero-extended |
| y_valid | output | 1 | One-cycle strobe on Y result update |
| done | output | 1 | One-cycle pulse when the read pair completes |

## Verification
The bench pairs the block with a behavioural SPI master. This master returns each frame's conversion one frame late, and it surrounds the 11 sample bits with fixed nonzero filler. The sweep covers every combination of busy-rise latency from 0 to 3 cycles and busy-high length from 1 to 4 cycles. A latency of 0 separates a true busy-rise wait from stepping while busy is still low. The varied lengths show whether the busy-fall wait is honoured. The X and Y sample values are distinct and include all-ones and all-zeros, so a swapped channel, an off-by-one frame or a wrong bit slice each produces a different wrong value. Every other run raises start again mid-pair to confirm it is ignored.

// File: rtl/adc_poll_pkg.sv
package adc_poll_pkg;

  localparam int CMD_W  = 17;
  localparam int RES_W  = 16;
  localparam int SMP_HI = 11;
  localparam int SMP_LO = 1;
  localparam int SMP_W  = SMP_HI - SMP_LO + 1;
  localparam int NCHAN  = 2;

  typedef enum logic [2:0] {
    PS_SETUP   = 3'd0,
    PS_IDLE    = 3'd1,
    PS_ISSUE   = 3'd2,
    PS_WAIT_HI = 3'd3,
    PS_WAIT_LO = 3'd4
  } poll_state_t;

endpackage

// File: rtl/adc_poll_fsm.sv
module adc_poll_fsm
  import adc_poll_pkg::*;
#(
  parameter int STEPS  = 3,
  parameter int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              busy,
  output logic              cfg_go,
  output logic              issue_go,
  output logic [STEP_W-1:0] step,
  output logic [NCHAN-1:0]  cap_go,
  output logic              done
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  poll_state_t state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic frame_end;

  assign frame_end = (state_q == PS_WAIT_LO) && !busy;
  assign cfg_go    = (state_q == PS_SETUP);
  assign issue_go  = (state_q == PS_ISSUE) && !busy;
  assign step      = step_q;

  // Frame k (k >= 1) ending carries the conversion of the command sent in frame k-1
  genvar ch;
  generate
    for (ch = 0; ch < NCHAN; ch++) begin : g_cap
      assign cap_go[ch] = frame_end && (step_q == STEP_W'(ch + 1));
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    case (state_q)
      PS_SETUP:   state_d = PS_IDLE;
      PS_IDLE: begin
        step_d = '0;
        if (start) state_d = PS_ISSUE;
      end
      PS_ISSUE:   if (!busy) state_d = PS_WAIT_HI;
      PS_WAIT_HI: if (busy)  state_d = PS_WAIT_LO;
      PS_WAIT_LO: begin
        if (!busy) begin
          if (step_q == LAST_STEP) begin
            state_d = PS_IDLE;
          end else begin
            step_d  = step_q + 1'b1;
            state_d = PS_ISSUE;
          end
        end
      end
      default:    state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_SETUP;
      step_q  <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done    <= frame_end && (step_q == LAST_STEP);
    end
  end

endmodule

// File: rtl/adc_poll_txreg.sv
module adc_poll_txreg
  import adc_poll_pkg::*;
#(
  parameter int               STEP_W = 2,
  parameter logic [CMD_W-1:0] CMD_X  = 17'h1A000,
  parameter logic [CMD_W-1:0] CMD_Y  = 17'h1E000,
  parameter logic             CPOL   = 1'b0,
  parameter logic             CPHA   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_go,
  input  logic              issue_go,
  input  logic [STEP_W-1:0] step,
  output logic [CMD_W-1:0]  tx,
  output logic              send,
  output logic              cpol,
  output logic              cpha
);

  // Even steps address X, odd steps address Y
  logic [CMD_W-1:0] cmd_sel;
  assign cmd_sel = step[0] ? CMD_Y : CMD_X;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx   <= '0;
      send <= 1'b0;
      cpol <= 1'b0;
      cpha <= 1'b0;
    end else begin
      send <= issue_go;
      if (issue_go) tx <= cmd_sel;
      if (cfg_go) begin
        cpol <= CPOL;
        cpha <= CPHA;
      end
    end
  end

endmodule

// File: rtl/adc_poll_result.sv
module adc_poll_result
  import adc_poll_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [SMP_W-1:0] field,
  output logic [RES_W-1:0] result,
  output logic             valid
);

  localparam int PAD_W = RES_W - SMP_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= cap;
      if (cap) result <= {{PAD_W{1'b0}}, field};
    end
  end

endmodule

// File: rtl/adc_pair_poller.sv
module adc_pair_poller
  import adc_poll_pkg::*;
#(
  parameter int               STEPS = 3,
  parameter logic [CMD_W-1:0] CMD_X = 17'h1A000,
  parameter logic [CMD_W-1:0] CMD_Y = 17'h1E000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             spi_busy,
  input  logic [CMD_W-1:0] spi_rx,
  output logic [CMD_W-1:0] spi_tx,
  output logic             spi_send,
  output logic             spi_cpol,
  output logic             spi_cpha,
  output logic [RES_W-1:0] x_result,
  output logic             x_valid,
  output logic [RES_W-1:0] y_result,
  output logic             y_valid,
  output logic             done
);

  localparam int STEP_W = $clog2(STEPS);

  logic              cfg_go;
  logic              issue_go;
  logic [STEP_W-1:0] step;
  logic [NCHAN-1:0]  cap_go;
  logic [RES_W-1:0]  res   [NCHAN];
  logic [NCHAN-1:0]  res_v;

  adc_poll_fsm #(.STEPS(STEPS), .STEP_W(STEP_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .busy(spi_busy),
    .cfg_go(cfg_go), .issue_go(issue_go), .step(step),
    .cap_go(cap_go), .done(done)
  );

  adc_poll_txreg #(.STEP_W(STEP_W), .CMD_X(CMD_X), .CMD_Y(CMD_Y)) u_tx (
    .clk(clk), .rst(rst), .cfg_go(cfg_go), .issue_go(issue_go),
    .step(step), .tx(spi_tx), .send(spi_send),
    .cpol(spi_cpol), .cpha(spi_cpha)
  );

  genvar ch;
  generate
    for (ch = 0; ch < NCHAN; ch++) begin : g_res
      adc_poll_result u_res (
        .clk(clk), .rst(rst), .cap(cap_go[ch]),
        .field(spi_rx[SMP_HI:SMP_LO]),
        .result(res[ch]), .valid(res_v[ch])
      );
    end
  endgenerate

  assign x_result = res[0];
  assign y_result = res[1];
  assign x_valid  = res_v[0];
  assign y_valid  = res_v[1];

endmodule

// File: rtl/adc_pair_poller_chk.sv
module adc_pair_poller_chk (
  input logic        clk,
  input logic        rst,
  input logic        spi_busy,
  input logic        spi_send,
  input logic        spi_cpha,
  input logic        spi_cpol,
  input logic [15:0] x_result,
  input logic [15:0] y_result,
  input logic        x_valid,
  input logic        y_valid,
  input logic        done
);

  // Outstanding-transfer tracker, independent of the sequencer state
  logic pend, seen_hi;
  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      seen_hi <= 1'b0;
    end else if (spi_send) begin
      pend    <= 1'b1;
      seen_hi <= 1'b0;
    end else if (pend && spi_busy) begin
      seen_hi <= 1'b1;
    end else if (pend && seen_hi && !spi_busy) begin
      pend    <= 1'b0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!spi_send && !x_valid && !y_valid && !done && x_result == 16'd0 && y_result == 16'd0));

  // R2
  spi_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (spi_cpha && !spi_cpol));

  // R5
  send_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    spi_send |=> !spi_send);

  // R6
  handshake_chk: assert property (@(posedge clk) disable iff (rst)
    spi_send |-> !pend);

  // R8
  x_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    x_valid |=> !x_valid);

  // R8
  y_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> !y_valid);

  // R8
  x_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !x_valid |-> $stable(x_result));

  // R9
  done_pair_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (y_valid && !spi_send));

endmodule

bind adc_pair_poller adc_pair_poller_chk u_chk (
  .clk(clk), .rst(rst), .spi_busy(spi_busy), .spi_send(spi_send),
  .spi_cpha(spi_cpha), .spi_cpol(spi_cpol),
  .x_result(x_result), .y_result(y_result),
  .x_valid(x_valid), .y_valid(y_valid), .done(done)
);

// File: tb/adc_pair_poller_tb.sv
module adc_pair_poller_tb;

  localparam logic [16:0] CMD_X = 17'h1A000;
  localparam logic [16:0] CMD_Y = 17'h1E000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy_m;
  logic [16:0] rx_m;
  logic [16:0] spi_tx;
  logic        spi_send, spi_cpol, spi_cpha;
  logic [15:0] x_result, y_result;
  logic        x_valid, y_valid, done;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;  // 125 MHz

  adc_pair_poller u_dut (
    .clk(clk), .rst(rst), .start(start), .spi_busy(busy_m), .spi_rx(rx_m),
    .spi_tx(spi_tx), .spi_send(spi_send), .spi_cpol(spi_cpol), .spi_cpha(spi_cpha),
    .x_result(x_result), .x_valid(x_valid), .y_result(y_result), .y_valid(y_valid),
    .done(done)
  );

  // Behavioural SPI master + ADC: conversion of frame n-1 returned at end of frame n
  int          lat_cfg = 1, dur_cfg = 2, cnt;
  logic        act, hi;
  logic [16:0] cur_cmd, prev_cmd;
  logic [10:0] sx, sy;

  function automatic logic [16:0] enc(input logic [16:0] c);
    return {5'b10110, (c == CMD_Y) ? sy : sx, 1'b1};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      busy_m <= 1'b0; act <= 1'b0; hi <= 1'b0; rx_m <= '0;
      prev_cmd <= CMD_X; cur_cmd <= CMD_X; cnt <= 0;
    end else if (!act) begin
      if (spi_send) begin
        act <= 1'b1; cur_cmd <= spi_tx;
        if (lat_cfg == 0) begin busy_m <= 1'b1; hi <= 1'b1; cnt <= dur_cfg - 1; end
        else begin hi <= 1'b0; cnt <= lat_cfg - 1; end
      end
    end else if (!hi) begin
      if (cnt == 0) begin busy_m <= 1'b1; hi <= 1'b1; cnt <= dur_cfg - 1; end
      else cnt <= cnt - 1;
    end else begin
      if (cnt == 0) begin
        busy_m <= 1'b0; act <= 1'b0; rx_m <= enc(prev_cmd); prev_cmd <= cur_cmd;
      end else cnt <= cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic run_pair(input int lat, input int dur, input logic [10:0] ax,
                          input logic [10:0] ay, input bit restart);
    logic [16:0] txs [3];
    int nsend = 0, nxv = 0, nyv = 0, ndone = 0;
    bit pulse_ok = 1, hs_ok = 1, done_ok = 1, got_done = 0, prev_send = 0;
    logic [15:0] xv = '0, yv = '0;
    lat_cfg = lat; dur_cfg = dur; sx = ax; sy = ay;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < 400 && !got_done; c++) begin
      start = (restart && c == 5);
      @(negedge clk);
      if (spi_send) begin
        if (nsend < 3) txs[nsend] = spi_tx;
        nsend++;
        if (prev_send) pulse_ok = 0;
        if (act || busy_m) hs_ok = 0;
      end
      if (x_valid) begin nxv++; xv = x_result; if (nyv != 0) done_ok = 0; end
      if (y_valid) begin nyv++; yv = y_result; end
      if (done) begin ndone++; got_done = 1; if (!y_valid) done_ok = 0; end
      prev_send = spi_send;
    end
    start = 1'b0;
    chk(nsend == 3, "R4", "transfer count", nsend, 3);
    if (restart) chk(nsend == 3, "R10", "transfers with mid-pair start", nsend, 3);
    chk(txs[0] == CMD_X, "R4", "first command", txs[0], CMD_X);
    chk(txs[1] == CMD_Y, "R4", "second command", txs[1], CMD_Y);
    chk(txs[2] == CMD_X, "R4", "third command", txs[2], CMD_X);
    chk(pulse_ok, "R5", "single-cycle send", 0, 1);
    chk(hs_ok, "R6", "send before busy handshake", 0, 1);
    chk(nxv == 1 && nyv == 1, "R8", "valid strobe count", nxv * 16 + nyv, 17);
    chk(xv == {5'b0, ax}, "R7", "x sample", xv, {5'b0, ax});
    chk(yv == {5'b0, ay}, "R7", "y sample", yv, {5'b0, ay});
    chk(ndone == 1 && done_ok, "R9", "done once with y_valid, after x", ndone, 1);
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      chk(!spi_send && !x_valid && !y_valid && !done, "R3", "activity in idle",
          spi_send, 0);
    end
    chk(x_result == {5'b0, ax} && y_result == {5'b0, ay}, "R8", "results held",
        {x_result, y_result}, {5'b0, ax, 5'b0, ay});
  endtask

  initial begin
    sx = '0; sy = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(!spi_send && !x_valid && !y_valid && !done, "R1", "strobes in reset",
        {spi_send, x_valid, y_valid, done}, 0);
    chk(x_result == 0 && y_result == 0, "R1", "results in reset",
        {x_result, y_result}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!spi_send && x_result == 0, "R1", "first cycle after reset", spi_send, 0);
    @(negedge clk);
    // R2
    chk(spi_cpol == 1'b0 && spi_cpha == 1'b1, "R2", "spi mode",
        {spi_cpol, spi_cpha}, 2'b01);
    // R3
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      chk(!spi_send, "R3", "send without start", spi_send, 0);
    end
    for (int lat = 0; lat < 4; lat++) begin
      for (int dur = 1; dur <= 4; dur++) begin
        int idx = lat * 4 + dur - 1;
        logic [10:0] ax = (idx == 0) ? 11'h7FF : 11'((idx * 389 + 17) & 'h7FF);
        logic [10:0] ay = (idx == 0) ? 11'h000 : 11'((idx * 613 + 1000) & 'h7FF);
        run_pair(lat, dur, ax, ay, idx[0]);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired: got %0d expected 0", 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule